// File: doc/BRIEF.md
# Sixteen-Channel Pulse-Width Generator with Staged Counts

This block produces up to sixteen independent rectangular waveforms. Each channel has a programmable high-phase length and low-phase length, counted in steps of a channel clock. The channel clock is the input clock divided by a power of two that is chosen per channel. A small word-addressed register port configures the block. Channel enables are switched through separate write-one-to-set and write-one-to-clear addresses, so no read-modify-write is needed.

New phase lengths are first written into a staging word. They reach the running counter only after an update request, and only at the end of a complete period, so no pulse is ever cut short. A per-channel busy bit shows that a staged update is still pending. Each channel also has a start level, which is driven during the first phase, and a finish level, which the pin holds while the channel is off. A per-pin gate forces the pin low.

Top module: `pwmx_top`

## Requirements
- R1: After reset every channel is off, all busy bits read 0, every pin is 0, and every readable register reads 0.
- R2: A write to address 0x02 turns on each channel whose data bit is 1. A write to 0x03 turns off each channel whose data bit is 1. Data bits that are 0 leave their channel unchanged. Address 0x04 reads the enable vector.
- R3: The divider exponent of channel n sits in bits 4n+3:4n of address 0x00 for n<8, and in bits 4(n-8)+3:4(n-8) of address 0x01 for n>=8. Both words read back as written. Each count step lasts 2^exponent input clocks.
- R4: The phase word of channel n sits at address 0x10+n, with the high count in bits 31:16 and the low count in bits 15:0. Once a channel is enabled, its pin holds the start level for high*2^exponent clocks, then the inverted start level for low*2^exponent clocks, and this repeats.
- R5: Writing a phase word without an update request does not change the running waveform.
- R6: A write to 0x05 with bit n set requests an update for channel n. While the channel runs, its busy bit (read at 0x05) is 1 from the cycle after the write until the current period ends. The new counts then start a fresh period, and busy reads 0 in that same cycle.
- R7: An update requested on a disabled channel loads on the next clock, so busy reads 1 for exactly one cycle.
- R8: A high count of 0 holds the pin at the inverted start level. A low count of 0 holds it at the start level.
- R9: Address 0x06 holds the start levels in bits 15:0 and the finish levels in bits 31:16. A disabled channel drives its finish level. Re-enabling a channel restarts it at the beginning of the high phase.
- R10: Address 0x07 holds one gate bit per pin. A pin whose gate bit is 0 stays 0 whatever its channel does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 5 | Word address for writes and reads |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_o | output | NUM_CH (16) | Gated channel pins |

## Verification
The bench builds the block with the default of sixteen channels. This puts both divider words and the top channel of each word within reach, so the table can place vectors on channels 0, 7, 9, 12 and 15. Divider exponents stay between 0 and 3 and counts stay small. This keeps whole periods short enough that the bench can measure every phase length in cycles and compare it with high or low times 2^exponent. It also makes the exact length of the busy window during a running update predictable from the position of the request inside the old period.

// File: rtl/pwmx_pkg.sv
package pwmx_pkg;

  // Register-format widths; the field layout is fixed by the address map.
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 5;
  localparam int CNT_W      = 16;
  localparam int PSC_W      = 4;
  localparam int CH_PER_PSC = DATA_W / PSC_W;
  localparam int MAX_CH     = 16;
  localparam int DIV_W      = (1 << PSC_W) - 1;
  localparam int FIN_LSB    = 16;

  // Word addresses.
  localparam logic [ADDR_W-1:0] A_PSC_A  = 5'h00;
  localparam logic [ADDR_W-1:0] A_PSC_B  = 5'h01;
  localparam logic [ADDR_W-1:0] A_EN_SET = 5'h02;
  localparam logic [ADDR_W-1:0] A_EN_CLR = 5'h03;
  localparam logic [ADDR_W-1:0] A_EN_ST  = 5'h04;
  localparam logic [ADDR_W-1:0] A_UPDATE = 5'h05;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 5'h06;
  localparam logic [ADDR_W-1:0] A_GATE   = 5'h07;
  localparam logic [ADDR_W-1:0] A_WAVE   = 5'h10;

  // Last divider count before a step ends: 2^p - 1.
  function automatic logic [DIV_W-1:0] psc_limit(input logic [PSC_W-1:0] p);
    logic [DIV_W:0] span;
    span = (DIV_W+1)'(1) << p;
    return DIV_W'(span - (DIV_W+1)'(1));
  endfunction

  // Steps in one full period.
  function automatic logic [CNT_W:0] phase_total(input logic [CNT_W-1:0] hi,
                                                 input logic [CNT_W-1:0] lo);
    return {1'b0, hi} + {1'b0, lo};
  endfunction

  // True while the position lies inside the high phase.
  function automatic logic in_high_phase(input logic [CNT_W-1:0] pos,
                                         input logic [CNT_W-1:0] hi);
    return pos < hi;
  endfunction

endpackage

// File: rtl/pwmx_regs.sv
module pwmx_regs
  import pwmx_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [DATA_W-1:0]              bus_wdata,
  output logic [DATA_W-1:0]              bus_rdata,
  input  logic [NUM_CH-1:0]              busy_i,
  output logic [NUM_CH-1:0]              en_o,
  output logic [NUM_CH-1:0][PSC_W-1:0]   psc_o,
  output logic [NUM_CH-1:0][DATA_W-1:0]  wave_o,
  output logic [NUM_CH-1:0]              upd_o,
  output logic [NUM_CH-1:0]              init_o,
  output logic [NUM_CH-1:0]              finish_o,
  output logic [NUM_CH-1:0]              gate_o
);

  localparam int WAVE_BASE = int'(A_WAVE);

  logic [NUM_CH-1:0]             en_q, init_q, fin_q, gate_q;
  logic [NUM_CH-1:0][PSC_W-1:0]  psc_q;
  logic [NUM_CH-1:0][DATA_W-1:0] wave_q;

  // Decoded write events, named for the assertions.
  logic              wr_psc_a, wr_psc_b, wr_set, wr_clr, wr_upd, wr_lvl, wr_gate;
  logic [NUM_CH-1:0] wr_wave;
  logic [NUM_CH-1:0] wmask;

  assign wmask    = bus_wdata[NUM_CH-1:0];
  assign wr_psc_a = bus_wr && (bus_addr == A_PSC_A);
  assign wr_psc_b = bus_wr && (bus_addr == A_PSC_B);
  assign wr_set   = bus_wr && (bus_addr == A_EN_SET);
  assign wr_clr   = bus_wr && (bus_addr == A_EN_CLR);
  assign wr_upd   = bus_wr && (bus_addr == A_UPDATE);
  assign wr_lvl   = bus_wr && (bus_addr == A_LEVEL);
  assign wr_gate  = bus_wr && (bus_addr == A_GATE);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_wdec
    assign wr_wave[g] = bus_wr && (int'(bus_addr) == WAVE_BASE + g);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      init_q <= '0;
      fin_q  <= '0;
      gate_q <= '0;
      psc_q  <= '0;
      wave_q <= '0;
    end else begin
      if (wr_set) en_q <= en_q | wmask;
      if (wr_clr) en_q <= en_q & ~wmask;
      if (wr_lvl) begin
        init_q <= bus_wdata[NUM_CH-1:0];
        fin_q  <= bus_wdata[FIN_LSB +: NUM_CH];
      end
      if (wr_gate) gate_q <= wmask;
      for (int i = 0; i < NUM_CH; i++) begin
        if (wr_psc_a && i < CH_PER_PSC)
          psc_q[i] <= bus_wdata[(i % CH_PER_PSC)*PSC_W +: PSC_W];
        if (wr_psc_b && i >= CH_PER_PSC)
          psc_q[i] <= bus_wdata[(i % CH_PER_PSC)*PSC_W +: PSC_W];
        if (wr_wave[i]) wave_q[i] <= bus_wdata;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_PSC_A) begin
      for (int i = 0; i < NUM_CH; i++)
        if (i < CH_PER_PSC) bus_rdata[(i % CH_PER_PSC)*PSC_W +: PSC_W] = psc_q[i];
    end else if (bus_addr == A_PSC_B) begin
      for (int i = 0; i < NUM_CH; i++)
        if (i >= CH_PER_PSC) bus_rdata[(i % CH_PER_PSC)*PSC_W +: PSC_W] = psc_q[i];
    end else if (bus_addr == A_EN_ST) begin
      bus_rdata[NUM_CH-1:0] = en_q;
    end else if (bus_addr == A_UPDATE) begin
      bus_rdata[NUM_CH-1:0] = busy_i;
    end else if (bus_addr == A_LEVEL) begin
      bus_rdata[NUM_CH-1:0]         = init_q;
      bus_rdata[FIN_LSB +: NUM_CH]  = fin_q;
    end else if (bus_addr == A_GATE) begin
      bus_rdata[NUM_CH-1:0] = gate_q;
    end else begin
      for (int i = 0; i < NUM_CH; i++)
        if (int'(bus_addr) == WAVE_BASE + i) bus_rdata = wave_q[i];
    end
  end

  assign en_o     = en_q;
  assign psc_o    = psc_q;
  assign wave_o   = wave_q;
  assign upd_o    = wr_upd ? wmask : '0;
  assign init_o   = init_q;
  assign finish_o = fin_q;
  assign gate_o   = gate_q;

  AST_EN_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_set) |-> ((en_q & $past(wmask)) == $past(wmask))); // R2
  AST_EN_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_clr) |-> ((en_q & $past(wmask)) == '0)); // R2
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_set) && !$past(wr_clr)) |-> $stable(en_q)); // R2

endmodule

// File: rtl/pwmx_chan.sv
module pwmx_chan
  import pwmx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] shd_hi_i,
  input  logic [CNT_W-1:0] shd_lo_i,
  input  logic             upd_req_i,
  input  logic             init_lvl_i,
  input  logic             finish_lvl_i,
  input  logic             gate_i,
  output logic             wave_o,
  output logic             busy_o
);

  localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1);
  localparam logic [CNT_W-1:0] POS_ONE = CNT_W'(1);
  localparam logic [CNT_W:0]   EXT_ONE = (CNT_W+1)'(1);

  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] pos_q, act_hi_q, act_lo_q;
  logic             pend_q;

  // Internal events, brought out as named wires.
  logic             tick_w, boundary_w, load_w, high_w;
  logic [CNT_W:0]   total_w;

  assign tick_w     = en_i && (div_q >= psc_limit(psc_i));
  assign total_w    = phase_total(act_hi_q, act_lo_q);
  assign boundary_w = tick_w && (({1'b0, pos_q} + EXT_ONE) >= total_w);
  assign load_w     = pend_q && (boundary_w || !en_i);
  assign high_w     = in_high_phase(pos_q, act_hi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      pos_q    <= '0;
      act_hi_q <= '0;
      act_lo_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (!en_i || tick_w) div_q <= '0;
      else                 div_q <= div_q + DIV_ONE;

      if (!en_i || boundary_w) pos_q <= '0;
      else if (tick_w)         pos_q <= pos_q + POS_ONE;

      if (load_w) begin
        act_hi_q <= shd_hi_i;
        act_lo_q <= shd_lo_i;
      end

      pend_q <= upd_req_i | (pend_q & ~load_w);
    end
  end

  assign busy_o = pend_q;
  assign wave_o = gate_i & (en_i ? (high_w ? init_lvl_i : ~init_lvl_i) : finish_lvl_i);

  AST_COUNTS_CHANGE_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(act_hi_q) || !$stable(act_lo_q)) |-> $past(load_w)); // R5
  AST_BUSY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_req_i) |-> busy_o); // R6
  AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load_w) && !$past(upd_req_i)) |-> !busy_o); // R6
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en_i) |-> (pos_q == '0 && div_q == '0)); // R9
  AST_POS_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && total_w != '0) |-> ({1'b0, pos_q} < total_w)); // R4

endmodule

// File: rtl/pwmx_top.sv
module pwmx_top
  import pwmx_pkg::*;
#(
  parameter int NUM_CH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [4:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_o
);

  logic [NUM_CH-1:0]             en_w, upd_w, init_w, fin_w, gate_w, busy_w;
  logic [NUM_CH-1:0][PSC_W-1:0]  psc_w;
  logic [NUM_CH-1:0][DATA_W-1:0] wave_w;

  pwmx_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy_i    (busy_w),
    .en_o      (en_w),
    .psc_o     (psc_w),
    .wave_o    (wave_w),
    .upd_o     (upd_w),
    .init_o    (init_w),
    .finish_o  (fin_w),
    .gate_o    (gate_w)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwmx_chan u_chan (
      .clk          (clk),
      .rst_n        (rst_n),
      .en_i         (en_w[g]),
      .psc_i        (psc_w[g]),
      .shd_hi_i     (wave_w[g][DATA_W-1:CNT_W]),
      .shd_lo_i     (wave_w[g][CNT_W-1:0]),
      .upd_req_i    (upd_w[g]),
      .init_lvl_i   (init_w[g]),
      .finish_lvl_i (fin_w[g]),
      .gate_i       (gate_w[g]),
      .wave_o       (pwm_o[g]),
      .busy_o       (busy_w[g])
    );
  end

endmodule

// File: tb/test_pwmx_top.sv
`timescale 1ns/1ps
module test_pwmx_top;

  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           bus_wr = 1'b0;
  logic [4:0]     bus_addr = '0;
  logic [31:0]    bus_wdata = '0;
  logic [31:0]    bus_rdata;
  logic [NCH-1:0] pwm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwmx_top #(.NUM_CH(NCH)) i_pwmx_top (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_o(pwm_o)
  );

  // Vector: ch[63:60] exp[59:56] hi[55:48] lo[47:40] init[39] | exp_hi[31:16] exp_lo[15:0]
  localparam logic [63:0] VEC [0:5] = '{
    {4'd0,  4'd0, 8'd4, 8'd2, 1'b1, 7'd0, 16'd4,  16'd2},
    {4'd3,  4'd1, 8'd3, 8'd5, 1'b0, 7'd0, 16'd6,  16'd10},
    {4'd7,  4'd2, 8'd2, 8'd1, 1'b1, 7'd0, 16'd8,  16'd4},
    {4'd9,  4'd1, 8'd5, 8'd3, 1'b1, 7'd0, 16'd10, 16'd6},
    {4'd15, 4'd3, 8'd1, 8'd2, 1'b0, 7'd0, 16'd8,  16'd16},
    {4'd12, 4'd0, 8'd1, 8'd1, 1'b1, 7'd0, 16'd1,  16'd1}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic count_level(input int ch, input logic lvl, output int n);
    n = 0;
    while (pwm_o[ch] == lvl && n < 5000) begin
      n++;
      @(negedge clk);
    end
  endtask

  // Count samples over n cycles where the pin differs from lvl.
  task automatic hold_level(input int ch, input logic lvl, input int n, output int bad);
    bad = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_o[ch] != lvl) bad++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run hung actual=200000 expected=fewer cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n, n2, bad;
    logic [3:0] ch;
    logic [3:0] ex;
    logic [7:0] hi, lo;
    logic init;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(pwm_o == '0, "R1", "pins after reset", pwm_o, 0);
    peek(5'h04, d); check(d == 0, "R1", "enable vector", d, 0);
    peek(5'h05, d); check(d == 0, "R1", "busy vector", d, 0);
    peek(5'h13, d); check(d == 0, "R1", "phase word 3", d, 0);
    peek(5'h06, d); check(d == 0, "R1", "level word", d, 0);

    // R2 set/clear independence
    bus_write(5'h02, 32'h4);
    bus_write(5'h02, 32'h20);
    peek(5'h04, d); check(d == 32'h24, "R2", "enable after two sets", d, 32'h24);
    bus_write(5'h02, 32'h0);
    peek(5'h04, d); check(d == 32'h24, "R2", "zero set ignored", d, 32'h24);
    bus_write(5'h03, 32'h4);
    peek(5'h04, d); check(d == 32'h20, "R2", "clear one channel", d, 32'h20);
    bus_write(5'h03, 32'hFFFF);
    peek(5'h04, d); check(d == 32'h0, "R2", "clear all", d, 0);

    // R3 readback of both divider words
    bus_write(5'h00, 32'h7654_3210);
    peek(5'h00, d); check(d == 32'h7654_3210, "R3", "divider word A", d, 32'h7654_3210);
    bus_write(5'h01, 32'h0FED_CBA9);
    peek(5'h01, d); check(d == 32'h0FED_CBA9, "R3", "divider word B", d, 32'h0FED_CBA9);

    // Table-driven waveform checks (R3, R4, R7, R9)
    for (int v = 0; v < 6; v++) begin
      ch = VEC[v][63:60]; ex = VEC[v][59:56];
      hi = VEC[v][55:48]; lo = VEC[v][47:40]; init = VEC[v][39];
      bus_write(5'h03, 32'hFFFF);
      bus_write(5'h07, 32'hFFFF);
      bus_write(5'h06, 32'(init) << ch);
      if (ch < 8) bus_write(5'h00, 32'(ex) << (4*ch));
      else        bus_write(5'h01, 32'(ex) << (4*(ch-8)));
      bus_write(5'h10 + 5'(ch), {8'd0, hi, 8'd0, lo});
      bus_write(5'h05, 32'd1 << ch);
      peek(5'h05, d); check(d[ch] == 1'b1, "R7", "busy right after idle update", d[ch], 1);
      @(negedge clk);
      peek(5'h05, d); check(d[ch] == 1'b0, "R7", "busy one cycle later", d[ch], 0);
      check(pwm_o[ch] == 1'b0, "R9", "disabled pin at finish level 0", pwm_o[ch], 0);
      bus_write(5'h02, 32'd1 << ch);
      count_level(ch, init, n);
      check(n == int'(VEC[v][31:16]), "R4", "high phase cycles", n, VEC[v][31:16]);
      count_level(ch, ~init, n);
      check(n == int'(VEC[v][15:0]), "R3", "low phase cycles", n, VEC[v][15:0]);
      count_level(ch, init, n);
      check(n == int'(VEC[v][31:16]), "R4", "second high phase", n, VEC[v][31:16]);
    end

    // R5 / R6 on channel 1, divider 1
    bus_write(5'h03, 32'hFFFF);
    bus_write(5'h00, 32'h0);
    bus_write(5'h06, 32'h2);
    bus_write(5'h11, {16'd3, 16'd3});
    bus_write(5'h05, 32'h2);
    idle(2);
    bus_write(5'h02, 32'h2);
    bus_write(5'h11, {16'd6, 16'd2});
    count_level(1, 1'b1, n);
    count_level(1, 1'b0, n);
    count_level(1, 1'b1, n);
    check(n == 3, "R5", "staged word ignored, high", n, 3);
    count_level(1, 1'b0, n);
    check(n == 3, "R5", "staged word ignored, low", n, 3);
    // Now at position 0 of a period of 6; request lands at position 2.
    bus_write(5'h05, 32'h2);
    n2 = 0;
    peek(5'h05, d);
    while (d[1] && n2 < 100) begin
      n2++;
      @(negedge clk);
      peek(5'h05, d);
    end
    check(n2 == 4, "R6", "busy cycles until period end", n2, 4);
    count_level(1, 1'b1, n);
    check(n == 6, "R6", "new high after load", n, 6);
    count_level(1, 1'b0, n);
    check(n == 2, "R6", "new low after load", n, 2);

    // R8 zero counts on channel 4
    bus_write(5'h03, 32'hFFFF);
    bus_write(5'h06, 32'h10);
    bus_write(5'h14, {16'd0, 16'd4});
    bus_write(5'h05, 32'h10);
    idle(2);
    bus_write(5'h02, 32'h10);
    hold_level(4, 1'b0, 24, bad);
    check(bad == 0, "R8", "zero high gives inverted level", bad, 0);
    bus_write(5'h14, {16'd4, 16'd0});
    bus_write(5'h05, 32'h10);
    n2 = 0;
    peek(5'h05, d);
    while (d[4] && n2 < 100) begin
      n2++;
      @(negedge clk);
      peek(5'h05, d);
    end
    hold_level(4, 1'b1, 24, bad);
    check(bad == 0, "R8", "zero low gives start level", bad, 0);

    // R9 finish level and restart on channel 4
    bus_write(5'h03, 32'h10);
    bus_write(5'h14, {16'd2, 16'd2});
    bus_write(5'h05, 32'h10);
    idle(2);
    bus_write(5'h06, 32'h0010_0000);
    check(pwm_o[4] == 1'b1, "R9", "finish level 1 while off", pwm_o[4], 1);
    bus_write(5'h02, 32'h10);
    count_level(4, 1'b0, n);
    check(n == 2, "R9", "start level phase", n, 2);
    @(negedge clk);
    bus_write(5'h03, 32'h10);
    hold_level(4, 1'b1, 8, bad);
    check(bad == 0, "R9", "disabled holds finish level", bad, 0);
    bus_write(5'h06, 32'h0);
    check(pwm_o[4] == 1'b0, "R9", "finish level 0 field", pwm_o[4], 0);
    bus_write(5'h06, 32'h0000_0010);
    bus_write(5'h02, 32'h10);
    count_level(4, 1'b1, n);
    check(n == 2, "R9", "re-enable restarts high phase", n, 2);

    // R10 gate
    bus_write(5'h06, 32'h0010_0010);
    bus_write(5'h07, 32'hFFEF);
    hold_level(4, 1'b0, 12, bad);
    check(bad == 0, "R10", "gated pin while running", bad, 0);
    bus_write(5'h03, 32'h10);
    hold_level(4, 1'b0, 6, bad);
    check(bad == 0, "R10", "gated pin while off at finish 1", bad, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule